// File: doc/BRIEF.md
# Soft-Sample Buffer and Decision Handshake Controller

This block surrounds an iterative block decoder. It collects soft samples one block at a time. It keeps them in one sample bank or in two alternating banks, and it launches a processing engine on each full block. When the engine finishes, the block hands the hard decisions to a receiver, one bit for each request. Samples enter under a valid qualifier. The block tells the sender through a ready-for-input flag whether it can take more, and it tells the receiver through a ready-for-output flag when a decoded block is waiting.

The decoding algorithm is outside this block. A built-in engine stub stands in for it, so the sequencing can be exercised. The stub copies the decision of each sample into a separate one-bit decision store. The decision is 1 when the two's-complement sample is negative and 0 otherwise. The stub then stays busy for a further number of cycles given at run time. The block length is a run-time input. It must lie between 1 and the maximum size set by a parameter, and it must stay unchanged while any block is in flight. The maximum size can be set to 20730 or beyond, and the sample width can be set from 3 to 6 bits. Everything is clocked on the rising edge and reset synchronously, active high.

Top module: `dbh_ctrl`

## Requirements
- R1: In the cycle after a synchronous reset, in_rdy is 1, out_rdy is 0, out_vld is 0 and ovf is 0, and both sample banks count as empty.
- R2: A sample is stored only in a cycle where in_vld and in_rdy are both high. In any other cycle in_data is ignored and the fill position does not advance.
- R3: With a single bank, in_rdy is low from the cycle after the last sample of a block is stored. It rises again in the same cycle that out_rdy rises for that block.
- R4: With two banks, in_rdy stays high after the first block is stored. It is low while both banks hold a block and one of them is still being processed.
- R5: With two banks, blocks are decoded and delivered in the order they were filled. A block is not started until every decision of the previous block has been read out.
- R6: While out_rdy is high, a cycle with out_req high delivers exactly one decision on out_bit, with out_vld high in the following cycle. Decision k is 1 when sample k of the block is negative in two's complement, and 0 otherwise.
- R7: A cycle in which out_req is low, or out_rdy is low, produces no out_vld in the next cycle. No decision is lost or repeated across such pauses.
- R8: out_rdy falls in the same cycle that the block_length-th decision shows out_vld high. After that, no further out_vld follows until the next block is ready.
- R9: An in_vld pulse while in_rdy is low is dropped, so it never shows up in any later output. It sets ovf, and ovf stays set until reset.
- R10: The block length is taken from blk_len at run time. Blocks of length 1 and of other lengths are each delivered with exactly that many decisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| blk_len | input | LEN_W | Samples per block, from 1 to MAX_N |
| eng_busy | input | BUSY_W | Extra busy cycles of the engine stub after its copy pass |
| in_vld | input | 1 | in_data carries a sample this cycle |
| in_data | input | SW | Soft sample, two's complement |
| in_rdy | output | 1 | Block can store a sample |
| ovf | output | 1 | Sticky: a sample was offered while in_rdy was low |
| out_req | input | 1 | Receiver asks for one decision |
| out_rdy | output | 1 | A decoded block is waiting to be read |
| out_bit | output | 1 | Hard decision |
| out_vld | output | 1 | out_bit is valid this cycle |

## Verification
The hardest situation to reach from the ports is in double-bank mode. A decoded block sits unread in the decision store while the other bank also holds a block, and a third block is being filled into the bank that was just freed. To get there, the bench fills two blocks back to back while the engine's busy time is long. It then withholds every request for several hundred cycles and fills a third block into the freed bank. Only then does it drain the three blocks, checking that each arrives whole and in fill order. Paced requests and gapped input are mixed in elsewhere, so that pauses on both sides are covered.

// File: rtl/dbh_pkg.sv
package dbh_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_COPY = 2'd1,
    ENG_HOLD = 2'd2
  } eng_state_t;
endpackage

// File: rtl/dbh_sample_ram.sv
module dbh_sample_ram #(
  parameter int SW    = 6,
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [SW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [SW-1:0] rdata
);
  logic [SW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dbh_dec_ram.sv
module dbh_dec_ram #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wbit,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic          rbit
);
  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wbit;
    if (re) rbit <= mem[raddr];
  end
endmodule

// File: rtl/dbh_engine_stub.sv
module dbh_engine_stub
  import dbh_pkg::*;
#(
  parameter int SW     = 6,
  parameter int MAX_N  = 256,
  parameter int LEN_W  = 9,
  parameter int IW     = 8,
  parameter int AW     = 9,
  parameter int BUSY_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              bank,
  input  logic [LEN_W-1:0]  len,
  input  logic [BUSY_W-1:0] busy,
  output logic [AW-1:0]     ram_raddr,
  input  logic [SW-1:0]     ram_rdata,
  output logic              dec_we,
  output logic [IW-1:0]     dec_waddr,
  output logic              dec_wbit,
  output logic              idle,
  output logic              done,
  output logic [LEN_W-1:0]  proc_len
);
  localparam logic [AW-1:0] BANK_OFS = AW'(MAX_N);

  eng_state_t        st_q;
  logic [IW-1:0]     cnt_q;
  logic [IW-1:0]     pa_q;
  logic              pv_q;
  logic [BUSY_W-1:0] wt_q;
  logic              bank_q;
  logic [LEN_W-1:0]  len_q;

  // read address for the sample bank; data returns one cycle later
  assign ram_raddr = bank_q ? (BANK_OFS + AW'(cnt_q)) : AW'(cnt_q);
  assign dec_we    = pv_q;
  assign dec_waddr = pa_q;
  assign dec_wbit  = ($signed(ram_rdata) < 0);
  assign idle      = (st_q == ENG_IDLE);
  assign done      = (st_q == ENG_HOLD) && (wt_q == '0) && !pv_q;
  assign proc_len  = len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ENG_IDLE;
      cnt_q  <= '0;
      pa_q   <= '0;
      pv_q   <= 1'b0;
      wt_q   <= '0;
      bank_q <= 1'b0;
      len_q  <= '0;
    end else begin
      pv_q <= (st_q == ENG_COPY);
      pa_q <= cnt_q;
      case (st_q)
        ENG_IDLE: if (start) begin
          bank_q <= bank;
          len_q  <= len;
          cnt_q  <= '0;
          st_q   <= ENG_COPY;
        end
        ENG_COPY: begin
          if (LEN_W'(cnt_q) == len_q - LEN_W'(1)) begin
            st_q <= ENG_HOLD;
            wt_q <= busy;
          end else begin
            cnt_q <= cnt_q + IW'(1);
          end
        end
        ENG_HOLD: begin
          if (wt_q != '0)  wt_q <= wt_q - BUSY_W'(1);
          else if (!pv_q)  st_q <= ENG_IDLE;
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbh_ctrl.sv
module dbh_ctrl #(
  parameter int SW         = 6,
  parameter int MAX_N      = 256,
  parameter int DOUBLE_BUF = 1,
  parameter int BUSY_W     = 16,
  parameter int LEN_W      = $clog2(MAX_N + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEN_W-1:0]  blk_len,
  input  logic [BUSY_W-1:0] eng_busy,
  input  logic              in_vld,
  input  logic [SW-1:0]     in_data,
  output logic              in_rdy,
  output logic              ovf,
  input  logic              out_req,
  output logic              out_rdy,
  output logic              out_bit,
  output logic              out_vld
);
  localparam int NB = (DOUBLE_BUF != 0) ? 2 : 1;
  localparam int IW = $clog2(MAX_N);
  localparam int AW = $clog2(NB * MAX_N);
  localparam logic [AW-1:0] BANK_OFS = AW'(MAX_N);

  logic [1:0]       full_q;
  logic             wr_bank_q, rd_bank_q;
  logic             wr_flip, rd_flip;
  logic [IW-1:0]    wr_idx_q;
  logic [IW-1:0]    out_cnt_q;
  logic [LEN_W-1:0] out_len_q;
  logic             accept, last_wr, take, eng_start;
  logic [AW-1:0]    wr_addr, eng_raddr;
  logic [SW-1:0]    eng_rdata;
  logic             eng_idle, eng_done, dec_we, dec_wbit;
  logic [IW-1:0]    dec_waddr;
  logic [LEN_W-1:0] eng_len;

  // bank alternation exists only when two banks are built
  generate
    if (DOUBLE_BUF != 0) begin : g_dbl
      assign wr_flip = ~wr_bank_q;
      assign rd_flip = ~rd_bank_q;
    end else begin : g_sgl
      assign wr_flip = 1'b0;
      assign rd_flip = 1'b0;
    end
  endgenerate

  assign in_rdy    = !full_q[wr_bank_q];
  assign accept    = in_vld && in_rdy;
  assign last_wr   = (LEN_W'(wr_idx_q) == blk_len - LEN_W'(1));
  assign wr_addr   = wr_bank_q ? (BANK_OFS + AW'(wr_idx_q)) : AW'(wr_idx_q);
  assign take      = out_req && out_rdy;
  assign eng_start = eng_idle && !out_rdy && full_q[rd_bank_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q    <= '0;
      wr_bank_q <= 1'b0;
      rd_bank_q <= 1'b0;
      wr_idx_q  <= '0;
      ovf       <= 1'b0;
      out_rdy   <= 1'b0;
      out_vld   <= 1'b0;
      out_cnt_q <= '0;
      out_len_q <= '0;
    end else begin
      if (accept) begin
        if (last_wr) begin
          wr_idx_q          <= '0;
          full_q[wr_bank_q] <= 1'b1;
          wr_bank_q         <= wr_flip;
        end else begin
          wr_idx_q <= wr_idx_q + IW'(1);
        end
      end
      if (in_vld && !in_rdy) ovf <= 1'b1;
      if (eng_done) begin
        full_q[rd_bank_q] <= 1'b0;
        rd_bank_q         <= rd_flip;
        out_rdy           <= 1'b1;
        out_cnt_q         <= '0;
        out_len_q         <= eng_len;
      end
      out_vld <= take;
      if (take) begin
        out_cnt_q <= out_cnt_q + IW'(1);
        if (LEN_W'(out_cnt_q) == out_len_q - LEN_W'(1)) out_rdy <= 1'b0;
      end
    end
  end

  dbh_sample_ram #(.SW(SW), .DEPTH(NB * MAX_N), .AW(AW)) u_sram (
    .clk   (clk),
    .we    (accept),
    .waddr (wr_addr),
    .wdata (in_data),
    .raddr (eng_raddr),
    .rdata (eng_rdata)
  );

  dbh_engine_stub #(
    .SW(SW), .MAX_N(MAX_N), .LEN_W(LEN_W), .IW(IW), .AW(AW), .BUSY_W(BUSY_W)
  ) u_eng (
    .clk       (clk),
    .rst       (rst),
    .start     (eng_start),
    .bank      (rd_bank_q),
    .len       (blk_len),
    .busy      (eng_busy),
    .ram_raddr (eng_raddr),
    .ram_rdata (eng_rdata),
    .dec_we    (dec_we),
    .dec_waddr (dec_waddr),
    .dec_wbit  (dec_wbit),
    .idle      (eng_idle),
    .done      (eng_done),
    .proc_len  (eng_len)
  );

  dbh_dec_ram #(.DEPTH(MAX_N), .AW(IW)) u_dram (
    .clk   (clk),
    .we    (dec_we),
    .waddr (dec_waddr),
    .wbit  (dec_wbit),
    .re    (take),
    .raddr (out_cnt_q),
    .rbit  (out_bit)
  );
endmodule

// File: rtl/dbh_ctrl_chk.sv
module dbh_ctrl_chk #(
  parameter int IW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          in_vld,
  input logic          in_rdy,
  input logic          ovf,
  input logic          out_req,
  input logic          out_rdy,
  input logic          out_vld,
  input logic [IW-1:0] wr_idx
);
  AST_IDLE_NO_ADVANCE: assert property (@(posedge clk) disable iff (rst) !in_vld |=> $stable(wr_idx)); // R2
  AST_RDY_BACK_WITH_OUT: assert property (@(posedge clk) disable iff (rst) $rose(out_rdy) |-> in_rdy); // R3
  AST_VLD_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst) out_vld |-> $past(out_req) && $past(out_rdy)); // R6
  AST_LAST_WITH_VLD: assert property (@(posedge clk) disable iff (rst) $fell(out_rdy) |-> out_vld); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) ovf |=> ovf); // R9
endmodule

bind dbh_ctrl dbh_ctrl_chk #(.IW(IW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .in_vld  (in_vld),
  .in_rdy  (in_rdy),
  .ovf     (ovf),
  .out_req (out_req),
  .out_rdy (out_rdy),
  .out_vld (out_vld),
  .wr_idx  (wr_idx_q)
);

// File: tb/test_dbh_ctrl.sv
`timescale 1ns/1ps
module test_dbh_ctrl;
  localparam int SW     = 6;
  localparam int MAX_N  = 256;
  localparam int BUSY_W = 16;
  localparam int LEN_W  = $clog2(MAX_N + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LEN_W-1:0]  blk_len = LEN_W'(8);
  logic [BUSY_W-1:0] eng_busy = '0;
  logic in_vld = 1'b0;
  logic [SW-1:0] in_data = '0;
  logic out_req = 1'b0;
  logic sel_single = 1'b0;

  logic d_in_rdy, d_ovf, d_out_rdy, d_out_bit, d_out_vld;
  logic s_in_rdy, s_ovf, s_out_rdy, s_out_bit, s_out_vld;
  logic in_rdy, ovf, out_rdy, out_bit, out_vld;

  int checks = 0;
  int errors = 0;
  bit exp_bits [3][MAX_N];

  always #5 clk = ~clk;

  dbh_ctrl #(.SW(SW), .MAX_N(MAX_N), .DOUBLE_BUF(1), .BUSY_W(BUSY_W)) i_dbh_ctrl (
    .clk(clk), .rst(rst), .blk_len(blk_len), .eng_busy(eng_busy),
    .in_vld(in_vld), .in_data(in_data), .in_rdy(d_in_rdy), .ovf(d_ovf),
    .out_req(out_req), .out_rdy(d_out_rdy), .out_bit(d_out_bit), .out_vld(d_out_vld)
  );

  dbh_ctrl #(.SW(SW), .MAX_N(MAX_N), .DOUBLE_BUF(0), .BUSY_W(BUSY_W)) i_dbh_ctrl_single (
    .clk(clk), .rst(rst), .blk_len(blk_len), .eng_busy(eng_busy),
    .in_vld(in_vld), .in_data(in_data), .in_rdy(s_in_rdy), .ovf(s_ovf),
    .out_req(out_req), .out_rdy(s_out_rdy), .out_bit(s_out_bit), .out_vld(s_out_vld)
  );

  assign in_rdy  = sel_single ? s_in_rdy  : d_in_rdy;
  assign ovf     = sel_single ? s_ovf     : d_ovf;
  assign out_rdy = sel_single ? s_out_rdy : d_out_rdy;
  assign out_bit = sel_single ? s_out_bit : d_out_bit;
  assign out_vld = sel_single ? s_out_vld : d_out_vld;

  task automatic chk_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] samp(input int seed, input int i);
    return SW'((i * 5 + seed * 11 + (i * i) % 7) & 63);
  endfunction

  task automatic do_reset(input bit single);
    @(negedge clk);
    sel_single = single;
    rst = 1'b1; in_vld = 1'b0; out_req = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // stores n samples; with gap>0 an idle cycle carrying junk precedes some samples
  task automatic send_block(input int n, input int seed, input int gap, input int slot);
    for (int i = 0; i < n; i++) begin
      if (gap > 0 && (i % gap) == 1) begin
        in_vld = 1'b0; in_data = ~samp(seed, i);
        @(negedge clk);
      end
      in_vld = 1'b1; in_data = samp(seed, i);
      exp_bits[slot][i] = in_data[SW-1];
      @(negedge clk);
    end
    in_vld = 1'b0; in_data = '1;
  endtask

  task automatic wait_out_rdy(input int limit);
    int t = 0;
    while (!out_rdy && t < limit) begin @(negedge clk); t++; end
    chk_eq("R6 out_rdy rises for decoded block", int'(out_rdy), 1);
  endtask

  task automatic drain(input int n, input int slot, input bit paced);
    int got = 0;
    int cyc = 0;
    bit taken_prev = 1'b0;
    bit req;
    wait_out_rdy(5000);
    while (got < n && cyc < 4 * n + 20) begin
      chk_eq("R7 out_vld only after accepted request", int'(out_vld), int'(taken_prev));
      if (out_vld) begin
        chk_eq("R6 decision value", int'(out_bit), int'(exp_bits[slot][got]));
        got++;
        if (got == n) chk_eq("R8 out_rdy low with last decision", int'(out_rdy), 0);
      end
      req = paced ? ((cyc % 3) != 0) : 1'b1;
      out_req = req;
      taken_prev = req && out_rdy;
      cyc++;
      @(negedge clk);
    end
    out_req = 1'b0;
    chk_eq("R10 decisions delivered equals block length", got, n);
    chk_eq("R8 no decision after last", int'(out_vld), 0);
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    chk_eq("R1 in_rdy after reset", int'(d_in_rdy), 1);
    chk_eq("R1 out_rdy after reset", int'(d_out_rdy), 0);
    chk_eq("R1 out_vld after reset", int'(d_out_vld), 0);
    chk_eq("R1 ovf after reset", int'(d_ovf), 0);
    chk_eq("R1 single in_rdy after reset", int'(s_in_rdy), 1);
    chk_eq("R1 single out_rdy after reset", int'(s_out_rdy), 0);
  endtask

  task automatic t_single_basic;
    do_reset(1'b1);
    blk_len = LEN_W'(12); eng_busy = BUSY_W'(30);
    send_block(12, 1, 0, 0);
    chk_eq("R3 single in_rdy low after last sample", int'(in_rdy), 0);
    repeat (10) @(negedge clk);
    chk_eq("R3 single in_rdy stays low while processing", int'(in_rdy), 0);
    wait_out_rdy(2000);
    chk_eq("R3 in_rdy back with out_rdy", int'(in_rdy), 1);
    drain(12, 0, 1'b0);
  endtask

  task automatic t_gaps_pauses;
    do_reset(1'b1);
    blk_len = LEN_W'(20); eng_busy = BUSY_W'(5);
    send_block(20, 2, 3, 0);  // R2 idle cycles carry junk data
    drain(20, 0, 1'b1);       // R7 paced requests
  endtask

  task automatic t_double_order;
    do_reset(1'b0);
    blk_len = LEN_W'(16); eng_busy = BUSY_W'(200);
    send_block(16, 3, 0, 0);
    chk_eq("R4 in_rdy high after first block", int'(in_rdy), 1);
    send_block(16, 4, 0, 1);
    chk_eq("R4 in_rdy low with both banks held", int'(in_rdy), 0);
    wait_out_rdy(3000);
    repeat (300) @(negedge clk);
    chk_eq("R5 first block still waiting unread", int'(out_rdy), 1);
    chk_eq("R4 freed bank accepts input", int'(in_rdy), 1);
    send_block(16, 5, 2, 2);
    chk_eq("R4 in_rdy low again after refill", int'(in_rdy), 0);
    drain(16, 0, 1'b1);  // R5 first filled block first
    drain(16, 1, 1'b0);  // R5 second block
    drain(16, 2, 1'b0);  // R5 third block
  endtask

  task automatic t_overflow;
    do_reset(1'b1);
    blk_len = LEN_W'(8); eng_busy = BUSY_W'(20);
    send_block(8, 6, 0, 0);
    chk_eq("R9 ovf clear before offer", int'(ovf), 0);
    for (int k = 0; k < 3; k++) begin
      in_vld = 1'b1; in_data = '0;
      @(negedge clk);
    end
    in_vld = 1'b0;
    chk_eq("R9 ovf set by dropped offer", int'(ovf), 1);
    drain(8, 0, 1'b0);
    send_block(8, 7, 0, 1);
    drain(8, 1, 1'b0);
    chk_eq("R9 ovf sticky", int'(ovf), 1);
  endtask

  task automatic t_len_one;
    do_reset(1'b0);
    blk_len = LEN_W'(1); eng_busy = BUSY_W'(0);
    send_block(1, 8, 0, 0);
    chk_eq("R4 in_rdy high after one-sample block", int'(in_rdy), 1);
    drain(1, 0, 1'b0);  // R10 length one
    do_reset(1'b1);
    blk_len = LEN_W'(1);
    send_block(1, 9, 0, 0);
    chk_eq("R3 single in_rdy low after one-sample block", int'(in_rdy), 0);
    drain(1, 0, 1'b1);  // R10 length one, single bank
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_single_basic();
    t_gaps_pauses();
    t_double_order();
    t_overflow();
    t_len_one();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule